// File: doc/BRIEF.md
# Rotating-Slice Prefetch Read FIFO

This block fetches sequential 32-bit words ahead of a consumer from a shared memory made of eight interleaved slices. The slices rotate past the block's memory port, one slice per clock. After a start command loads an address, the block waits until the rotation presents the slice that holds that address. It then issues one read per clock for consecutive addresses, and each result returns a fixed five clocks later and is written into local storage.

Issuing stops once the stored level reaches a threshold of 14. The reads already in flight still land, so the storage holds 19 entries: the threshold plus the five-clock return latency. When the consumer drains the level below the threshold, issuing resumes at the next clock on which the rotation lines up with the next address. A stop command, or a new start, empties the storage and drops any returns still in flight. The same port also carries block-transfer traffic, and that traffic yields in any clock in which the FIFO issues a read.

Top module: `rot_prefetch_fifo`

## Requirements
- R1: After reset the FIFO is empty, `level` is 0 and no read is issued. The rotating slice is 0 in the first clock after reset and advances by one, modulo 8, on every clock.
- R2: A read is issued only in a clock in which the rotating slice equals bits [2:0] of the read address.
- R3: Read addresses follow each other by +1, starting at the start address. After a pause, issuing resumes at the address after the last one issued.
- R4: A read is issued in a clock exactly when the block is started and not stopped, `level` is below 14, and the slice is aligned with the next address.
- R5: `level` never exceeds 19. With no pops, exactly 19 reads are issued after a start and `level` settles at 19.
- R6: `pop_data` shows the oldest stored word whenever `empty` is low. Pops return the words in address order. `empty` is high exactly when `level` is 0.
- R7: Read data is accepted 5 clocks after its command. On each clock, `level` rises by one for an accepted return and falls by one for an accepted pop, and stays unchanged when both happen.
- R8: `blk_gnt` equals `blk_req` in clocks with no read issued, and is low in clocks in which a read is issued.
- R9: A pop while empty is ignored: `level` and the data order are unchanged, and `stall` is high in that clock.
- R10: A stop or a new start clears the FIFO on the next clock. Returns belonging to reads issued before it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load `start_addr`, flush, begin prefetching |
| stop | input | 1 | Halt prefetching and flush |
| start_addr | input | 16 | Word address for the first read |
| rd_cmd | output | 1 | Read command to the shared memory |
| rd_addr | output | 16 | Word address of the read command |
| rd_valid | input | 1 | Returned data valid, 5 clocks after the command |
| rd_data | input | 32 | Returned data word |
| blk_req | input | 1 | Block transfer wants the shared port |
| blk_gnt | output | 1 | Block transfer may use the port this clock |
| pop | input | 1 | Consumer takes the head word |
| pop_data | output | 32 | Head word |
| empty | output | 1 | No word stored |
| stall | output | 1 | Pop attempted while empty |
| level | output | 5 | Number of stored words |

## Verification
A wrong rotation phase or next-address register shows up in the first clock of a read, because `rd_addr` no longer matches the slice the bench expects or breaks the +1 sequence. A miscounted level shows within one clock as a mismatch with the bench's step-by-step level, and over a fill with no pops as a final level other than 19. A broken pointer or a missed discard is seen at the next pop, when `pop_data` differs from the word for the expected address.

// File: rtl/rot_prefetch_fifo.sv
module rot_prefetch_fifo #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int SLICES = 8,
  parameter int LAT    = 5,
  parameter int THRESH = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic [AW-1:0] start_addr,
  output logic          rd_cmd,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic          blk_req,
  output logic          blk_gnt,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          empty,
  output logic          stall,
  output logic [$clog2(THRESH+LAT+1)-1:0] level
);
  localparam int SW    = $clog2(SLICES);
  localparam int DEPTH = THRESH + LAT;
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [SW-1:0]  rot;
  logic           active;
  logic [AW-1:0]  nxt;
  logic [LAT-1:0] track;
  logic [DW-1:0]  store [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [CW-1:0]  count;

  wire flush  = start | stop;
  wire push   = rd_valid & track[LAT-1];
  wire pop_ok = pop & (count != '0);

  assign rd_cmd   = active && (nxt[SW-1:0] == rot) && (count < CW'(THRESH));
  assign rd_addr  = nxt;
  assign blk_gnt  = blk_req & ~rd_cmd;
  assign empty    = (count == '0);
  assign stall    = pop & empty;
  assign level    = count;
  assign pop_data = store[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot    <= '0;
      active <= 1'b0;
      nxt    <= '0;
      track  <= '0;
      wp     <= '0;
      rp     <= '0;
      count  <= '0;
    end else begin
      rot <= rot + 1'b1;
      if (flush) begin
        active <= start;
        track  <= '0;
        wp     <= '0;
        rp     <= '0;
        count  <= '0;
        if (start) nxt <= start_addr;
      end else begin
        track <= {track[LAT-2:0], rd_cmd};
        if (rd_cmd) nxt <= nxt + 1'b1;
        if (push)   wp  <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
        if (pop_ok) rp  <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
        count <= count + CW'(push) - CW'(pop_ok);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) store[wp] <= rd_data;
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push && !flush |-> (count < CW'(DEPTH)) || pop_ok);

  p_seq_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd && $past(rd_cmd) && !$past(flush) |-> rd_addr == $past(rd_addr) + 1'b1);

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  p_level_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flush) |-> (count == $past(count)) || (count == $past(count) + 1'b1)
                      || (count + 1'b1 == $past(count)));

  p_idle_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !start |=> !rd_cmd);
endmodule

// File: tb/sim_rot_prefetch_fifo.sv
`timescale 1ns/1ps
module sim_rot_prefetch_fifo;
  localparam int LAT = 5;
  localparam int THR = 14;
  localparam int DEP = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, pop = 0, blk_req = 0;
  logic [15:0] start_addr = '0;
  logic rd_cmd, rd_valid, blk_gnt, empty, stall;
  logic [15:0] rd_addr;
  logic [31:0] rd_data, pop_data;
  logic [4:0] level;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rot_prefetch_fifo u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .start_addr(start_addr),
    .rd_cmd(rd_cmd), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .blk_req(blk_req), .blk_gnt(blk_gnt), .pop(pop), .pop_data(pop_data),
    .empty(empty), .stall(stall), .level(level));

  function automatic logic [31:0] fdat(input logic [15:0] a);
    return {~a, a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory model: fixed latency, live bit marks returns the FIFO must keep
  logic        s_v [LAT];
  logic        s_l [LAT];
  logic [15:0] s_a [LAT];
  always @(posedge clk) begin
    s_v[0] <= rd_cmd;
    s_a[0] <= rd_addr;
    s_l[0] <= rd_cmd && !(start || stop);
    for (int i = 1; i < LAT; i++) begin
      s_v[i] <= s_v[i-1];
      s_a[i] <= s_a[i-1];
      s_l[i] <= s_l[i-1] && !(start || stop);
    end
  end
  initial for (int i = 0; i < LAT; i++) begin s_v[i] = 0; s_l[i] = 0; s_a[i] = '0; end
  assign rd_valid = s_v[LAT-1];
  assign rd_data  = fdat(s_a[LAT-1]);

  // cycle monitor, samples half a nanosecond before each rising edge
  logic [2:0]  rot_m = '0;
  bit          act_m = 0, have_prev = 0;
  logic [15:0] next_m = '0, pop_m = '0;
  int          plev = 0, ppush = 0, ppop = 0, issued_m = 0;

  always begin
    bit exp_cmd;
    @(negedge clk); #1.5;
    if (!rst_n) begin
      rot_m = '0; act_m = 0; have_prev = 0;
    end else begin
      exp_cmd = act_m && (level < THR) && (next_m[2:0] == rot_m);
      check(rd_cmd == exp_cmd, "R4", rd_cmd, exp_cmd);
      if (rd_cmd) begin
        check(rd_addr[2:0] == rot_m, "R2", rd_addr[2:0], rot_m);
        check(rd_addr == next_m, "R3", rd_addr, next_m);
      end
      check(blk_gnt == (blk_req && !rd_cmd), "R8", blk_gnt, blk_req && !rd_cmd);
      check(level <= DEP, "R5", level, DEP);
      check(empty == (level == 0), "R6", empty, level == 0);
      check(stall == (pop && level == 0), "R9", stall, pop && level == 0);
      if (have_prev) check(int'(level) == plev + ppush - ppop, "R7", level, plev + ppush - ppop);
      if (pop && level != 0) begin
        check(pop_data == fdat(pop_m), "R6", pop_data, fdat(pop_m));
        pop_m++;
      end
      if (start || stop) begin
        plev = 0; ppush = 0; ppop = 0;
      end else begin
        plev = level; ppush = (rd_valid && s_l[LAT-1]) ? 1 : 0; ppop = (pop && level != 0) ? 1 : 0;
      end
      have_prev = 1;
      if (rd_cmd) begin next_m++; issued_m++; end
      if (start) begin act_m = 1; next_m = start_addr; pop_m = start_addr; issued_m = 0; end
      if (stop) act_m = 0;
      rot_m++;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
    blk_req = $urandom_range(0, 1);
  endtask

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    #0.2;
    check(level == 0 && empty && !rd_cmd, "R1", {level, empty, rd_cmd}, 7'b0000010);
    for (int k = 0; k < 9; k++) begin
      logic [15:0] a;
      a = (k == 8) ? 16'hFFFA : 16'h1000 + 16'(k * 13);
      tick(); start_addr = a; start = 1;
      tick(); start = 0;
      repeat (40) tick();
      check(level == DEP, "R5", level, DEP);
      check(issued_m == DEP, "R5", issued_m, DEP);
      pop = 1;
      repeat (25) tick();
      for (int c = 0; c < 250; c++) begin
        tick();
        pop = ($urandom_range(0, 3) < (k % 4) + 1);
      end
      tick(); pop = 0;
      if (k % 2) begin
        start_addr = a + 16'h0400; start = 1;
        tick(); start = 0;
        repeat (3) tick();
      end
      stop = 1;
      tick(); stop = 0;
      repeat (8) tick();
      #0.2;
      check(level == 0 && empty, "R10", level, 0);
      check(!rd_cmd, "R10", rd_cmd, 0);
      pop = 1;
      #0.2;
      check(stall == 1'b1, "R9", stall, 1);
      tick(); pop = 0;
      tick();
      check(level == 0, "R9", level, 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule